// File: doc/BRIEF.md
# SDRAM Auto Refresh Scheduler

This block keeps an SDRAM array of 8,192 rows refreshed. A free-running timer marks each point at which one more refresh falls due. Each tick adds to a count of outstanding refreshes, and that count is used to postpone refreshes while the memory is busy. As long as the count is non-zero, the block asks the access sequencer for the command bus. It waits until the sequencer signals that it is idle, so a data burst in flight is never cut short. It then takes the bus and closes every bank with one precharge-all command. After the precharge time it issues an auto refresh command, and after that it leaves the bus silent for the refresh cycle time.

While it holds the bus, the block keeps issuing refreshes at the refresh cycle spacing until the count reaches zero, and only then hands the bus back. In the default distributed mode, each tick adds one refresh, with ticks about 7.81 µs apart (781 clocks at 100 MHz). In burst mode, one tick per 64 ms window adds the whole 8,192 refreshes, and they are then issued back to back. The refresh command carries no address, because the device counts rows itself. An urgency flag tells the sequencer when too many refreshes have been put off.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_o, own_bus_o and urgent_o are 0, cmd_o is 2'b00 (no operation) and debt_o is 0.
- R2: In distributed mode (burst_mode_i = 0), debt_o grows by one at every TICK_CYCLES-th clock edge after reset release. It shrinks by one at the edge that ends each cycle in which an auto refresh is shown on cmd_o.
- R3: In burst mode (burst_mode_i = 1), debt_o grows by BURST_REFS at every WINDOW_CYCLES-th clock edge after reset release. The refreshes that make up the debt are then issued back to back.
- R4: urgent_o is 1 exactly when debt_o is at least URGENT_LIMIT.
- R5: In the cycle after debt_o is seen non-zero while the bus is not held, req_o is 1. Once raised, req_o stays 1 until the bus is taken, and own_bus_o is never 1 while req_o is 0.
- R6: own_bus_o rises only in the cycle after a cycle in which both req_o and idle_ack_i were 1.
- R7: In the first cycle that own_bus_o is 1, cmd_o is 2'b01 (precharge all banks). A precharge-all appears at no other time.
- R8: The first auto refresh (cmd_o = 2'b10) of each bus tenure appears exactly TRP_CYCLES cycles after the precharge-all.
- R9: Consecutive auto refreshes in one tenure are exactly TRC_CYCLES cycles apart. cmd_o is 2'b00 whenever own_bus_o is 0.
- R10: The bus is released (own_bus_o and req_o fall together) exactly TRC_CYCLES cycles after the last auto refresh, and only when debt_o was 0 in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode_i | input | 1 | 1 selects one full-array refresh burst per window, 0 selects one refresh per interval |
| idle_ack_i | input | 1 | Access sequencer is idle and yields the command bus |
| req_o | output | 1 | Refresh wants the command bus |
| own_bus_o | output | 1 | Refresh currently drives the command bus |
| cmd_o | output | 2 | 00 no operation, 01 precharge all, 10 auto refresh |
| debt_o | output | DEBT_W | Number of refreshes due but not yet issued |
| urgent_o | output | 1 | Outstanding refreshes have reached URGENT_LIMIT |

## Verification
A wrong outstanding-refresh count appears on debt_o and urgent_o in the very cycle it goes astray. The bench compares both every cycle against a count it derives from elapsed clocks and observed refresh commands. A wrong sequencer state shows at once on cmd_o or own_bus_o. It can show as a command outside a bus tenure, a precharge that does not open the tenure, a refresh off the precharge or cycle-time grid, or a release taken with refreshes still owed. Each of these is caught on the first cycle where the spacing or handshake rule breaks.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_PRE_ALL = 2'b01,
    CMD_AREF    = 2'b10
  } ref_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_PRE,
    ST_WAIT_RP,
    ST_AREF,
    ST_WAIT_RC
  } ref_state_e;

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
  parameter int INTERVAL = 781,
  parameter int WINDOW   = 6_400_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_i,
  output logic tick_o
);
  localparam int MAXP = (INTERVAL > WINDOW) ? INTERVAL : WINDOW;
  localparam int CW   = $clog2(MAXP + 1);

  logic [CW-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit  = burst_i ? CW'(WINDOW - 1) : CW'(INTERVAL - 1);
    tick_o = (cnt_q >= limit);
    cnt_d  = tick_o ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
  parameter int DEBT_W       = 15,
  parameter int BURST_REFS   = 8192,
  parameter int URGENT_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              burst_i,
  input  logic              dec_i,
  output logic [DEBT_W-1:0] debt_o,
  output logic              urgent_o
);
  localparam logic [DEBT_W:0] MAXV      = {1'b0, {DEBT_W{1'b1}}};
  localparam logic [DEBT_W:0] BURST_ADD = (DEBT_W+1)'(BURST_REFS);

  logic [DEBT_W-1:0] debt_q, debt_d;
  logic [DEBT_W:0]   add, sum;
  logic              debt_en;

  always_comb begin
    add     = tick_i ? (burst_i ? BURST_ADD : (DEBT_W+1)'(1)) : '0;
    sum     = {1'b0, debt_q} + add - {{DEBT_W{1'b0}}, dec_i};
    debt_en = tick_i | dec_i;
    debt_d  = (sum > MAXV) ? {DEBT_W{1'b1}} : sum[DEBT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       debt_q <= '0;
    else if (debt_en) debt_q <= debt_d;
  end

  assign debt_o   = debt_q;
  assign urgent_o = (debt_q >= DEBT_W'(URGENT_LIMIT));

  // a refresh is only ever issued against an outstanding one
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> (debt_q != '0));

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import sdram_refresh_pkg::*;
#(
  parameter int TRP_CYCLES = 3,
  parameter int TRC_CYCLES = 7,
  parameter int DEBT_W     = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEBT_W-1:0] debt_i,
  input  logic              idle_ack_i,
  output logic              req_o,
  output logic              own_bus_o,
  output ref_cmd_e          cmd_o,
  output logic              dec_o
);
  localparam int WMAX = (TRP_CYCLES > TRC_CYCLES) ? TRP_CYCLES : TRC_CYCLES;
  localparam int WW   = $clog2(WMAX + 1);

  ref_state_e    state_q, state_d;
  logic [WW-1:0] wait_q, wait_d;
  logic          wait_en;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    wait_en = 1'b0;
    cmd_o   = CMD_NOP;
    dec_o   = 1'b0;
    case (state_q)
      ST_IDLE:    if (debt_i != '0) state_d = ST_REQ;
      ST_REQ:     if (idle_ack_i)   state_d = ST_PRE;
      ST_PRE: begin
        cmd_o   = CMD_PRE_ALL;
        wait_d  = WW'(TRP_CYCLES - 1);
        wait_en = 1'b1;
        state_d = ST_WAIT_RP;
      end
      ST_WAIT_RP: begin
        if (wait_q == WW'(1)) state_d = ST_AREF;
        else begin
          wait_d  = wait_q - WW'(1);
          wait_en = 1'b1;
        end
      end
      ST_AREF: begin
        cmd_o   = CMD_AREF;
        dec_o   = 1'b1;
        wait_d  = WW'(TRC_CYCLES - 1);
        wait_en = 1'b1;
        state_d = ST_WAIT_RC;
      end
      ST_WAIT_RC: begin
        if (wait_q == WW'(1)) state_d = (debt_i == '0) ? ST_IDLE : ST_AREF;
        else begin
          wait_d  = wait_q - WW'(1);
          wait_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      if (wait_en) wait_q <= wait_d;
    end
  end

  assign req_o     = (state_q != ST_IDLE);
  assign own_bus_o = (state_q != ST_IDLE) && (state_q != ST_REQ);

  assert_grant_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_bus_o) |-> $past(idle_ack_i && req_o));

  assert_pre_opens_tenure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_bus_o) |-> (cmd_o == CMD_PRE_ALL));

  assert_cmd_needs_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != CMD_NOP) |-> own_bus_o);

  assert_release_debt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own_bus_o) |-> ($past(debt_i) == '0));

  assert_req_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !own_bus_o) |=> req_o);

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_refresh_pkg::*;
#(
  parameter int TICK_CYCLES   = 781,
  parameter int WINDOW_CYCLES = 6_400_000,
  parameter int BURST_REFS    = 8192,
  parameter int TRP_CYCLES    = 3,
  parameter int TRC_CYCLES    = 7,
  parameter int URGENT_LIMIT  = 8,
  parameter int DEBT_W        = $clog2(2 * BURST_REFS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_mode_i,
  input  logic              idle_ack_i,
  output logic              req_o,
  output logic              own_bus_o,
  output logic [1:0]        cmd_o,
  output logic [DEBT_W-1:0] debt_o,
  output logic              urgent_o
);
  logic     tick;
  logic     dec;
  ref_cmd_e cmd;

  refresh_tick_gen #(
    .INTERVAL (TICK_CYCLES),
    .WINDOW   (WINDOW_CYCLES)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .burst_i (burst_mode_i),
    .tick_o  (tick)
  );

  refresh_debt #(
    .DEBT_W       (DEBT_W),
    .BURST_REFS   (BURST_REFS),
    .URGENT_LIMIT (URGENT_LIMIT)
  ) u_debt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .burst_i  (burst_mode_i),
    .dec_i    (dec),
    .debt_o   (debt_o),
    .urgent_o (urgent_o)
  );

  refresh_seq #(
    .TRP_CYCLES (TRP_CYCLES),
    .TRC_CYCLES (TRC_CYCLES),
    .DEBT_W     (DEBT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .debt_i     (debt_o),
    .idle_ack_i (idle_ack_i),
    .req_o      (req_o),
    .own_bus_o  (own_bus_o),
    .cmd_o      (cmd),
    .dec_o      (dec)
  );

  assign cmd_o = cmd;

endmodule

// File: tb/test_sdram_refresh_sched.sv
module test_sdram_refresh_sched;
  localparam int TICK   = 40;
  localparam int WIN    = 400;
  localparam int BURST  = 16;
  localparam int TRP    = 3;
  localparam int TRC    = 6;
  localparam int LIMIT  = 4;
  localparam int DW     = $clog2(2 * BURST + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          burst_mode = 1'b0;
  logic          idle_ack = 1'b0;
  logic          req, own_bus, urgent;
  logic [1:0]    cmd;
  logic [DW-1:0] debt;

  int tests = 0, fails = 0;
  int ecnt = 0;
  bit done = 0;

  int  refs_done, pre_n, ref_n, prev_debt;
  bit  prev_own, prev_req, prev_ack, after_pre;
  int  ack_mode;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  sdram_refresh_sched #(
    .TICK_CYCLES (TICK), .WINDOW_CYCLES (WIN), .BURST_REFS (BURST),
    .TRP_CYCLES (TRP), .TRC_CYCLES (TRC), .URGENT_LIMIT (LIMIT), .DEBT_W (DW)
  ) i_sdram_refresh_sched (
    .clk (clk), .rst_n (rst_n), .burst_mode_i (burst_mode), .idle_ack_i (idle_ack),
    .req_o (req), .own_bus_o (own_bus), .cmd_o (cmd), .debt_o (debt), .urgent_o (urgent)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int exp_debt(input int n, input bit bm, input int done_refs);
    if (bm) return (n / WIN) * BURST - done_refs;
    return (n / TICK) - done_refs;
  endfunction

  task automatic do_reset(input bit bm);
    @(negedge clk);
    rst_n = 1'b0;
    idle_ack = 1'b0;
    burst_mode = bm;
    repeat (3) @(negedge clk);
    chk(req == 0 && own_bus == 0 && urgent == 0, "R1 flags in reset", {req, own_bus, urgent}, 0);
    chk(cmd == 2'b00 && debt == 0, "R1 cmd/debt in reset", {cmd, debt}, 0);
    rst_n = 1'b1;
    refs_done = 0; pre_n = 0; ref_n = 0; prev_debt = 0;
    prev_own = 0; prev_req = 0; prev_ack = 0; after_pre = 0;
  endtask

  task automatic step();
    int n, e;
    @(negedge clk);
    n = ecnt;
    e = exp_debt(n, burst_mode, refs_done);
    chk(int'(debt) == e, burst_mode ? "R3 debt" : "R2 debt", int'(debt), e);
    chk(urgent == (e >= LIMIT), "R4 urgent", urgent, int'(e >= LIMIT));
    if (prev_debt != 0 && !prev_req) chk(req == 1, "R5 request raised", req, 1);
    if (prev_req && !prev_own && !own_bus) chk(req == 1, "R5 request held", req, 1);
    if (!req) chk(own_bus == 0, "R5 bus without request", own_bus, 0);
    if (own_bus && !prev_own) begin
      chk(prev_req && prev_ack, "R6 grant after ack", int'(prev_req && prev_ack), 1);
      chk(cmd == 2'b01, "R7 precharge opens tenure", cmd, 1);
    end
    if (cmd == 2'b01) chk(own_bus && !prev_own, "R7 stray precharge", own_bus, 1);
    if (!own_bus) chk(cmd == 2'b00, "R9 idle bus quiet", cmd, 0);
    if (cmd == 2'b10) begin
      if (after_pre) chk(n - pre_n == TRP, "R8 precharge to refresh", n - pre_n, TRP);
      else           chk(n - ref_n == TRC, "R9 refresh spacing", n - ref_n, TRC);
    end
    if (prev_own && !own_bus) begin
      chk(n - ref_n == TRC, "R10 release timing", n - ref_n, TRC);
      chk(prev_debt == 0, "R10 release with debt", prev_debt, 0);
      chk(req == 0, "R10 request drops", req, 0);
    end
    if (cmd == 2'b10) begin refs_done++; ref_n = n; after_pre = 0; end
    if (cmd == 2'b01) begin pre_n = n; after_pre = 1; end
    prev_own = own_bus; prev_req = req; prev_debt = int'(debt);
    case (ack_mode)
      0: idle_ack = 1'b0;
      1: idle_ack = ($urandom % 4) == 0;
      default: idle_ack = 1'b1;
    endcase
    prev_ack = idle_ack;
  endtask

  task automatic run(input int cycles, input int mode);
    ack_mode = mode;
    for (int i = 0; i < cycles; i++) step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    ack_mode = 0;
    // distributed mode: starve, then random, then always idle
    do_reset(1'b0);
    run(210, 0);
    chk(urgent == 1, "R4 urgent after starving", urgent, 1);
    run(2000, 1);
    run(400, 2);
    // burst mode: random acks, then starve over two windows, then drain
    do_reset(1'b1);
    run(1250, 1);
    run(560, 0);
    chk(int'(debt) >= BURST, "R3 burst debt accumulated", int'(debt), BURST);
    run(400, 2);
    chk(debt == 0, "R3 burst drained", int'(debt), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule